// File: doc/BRIEF.md
# Pulse-Command GPIO Block

This block drives and samples 24 general-purpose I/O channels through a small register interface. Software sets each channel as an input or an output and sets the level an output drives. The level on every pad passes through a two-stage synchroniser, and software reads the resulting snapshot from an input register.

The eight upper channels can also produce a timed pulse command. Software writes a mask that picks which of these channels take part, and a 20-bit pulse length in clock cycles. It then writes a start bit. All picked channels go high on one clock edge and go low on one later clock edge. One shared down-counter times every pulse, so the channels can never be out of phase and always have the same width. A busy flag reports whether a pulse is running. The mask and the length are copied at start, so software can prepare the next pulse while the current one is running.

Top module: `gpio_pulse_unit`

## Requirements
- R1: While reset is active and after it, every `pin_oe` bit and every `pin_out` bit is 0. Registers 0 (direction), 1 (output level), 3 (pulse mask), 4 (pulse length) and the busy flag all read 0.
- R2: Register 0 holds one direction bit per channel (bit i is channel i, 1 = output). `pin_oe` equals this register in the cycle after the write.
- R3: Register 1 holds one output level per channel (bit i is channel i). A channel that is not pulsing drives this level on `pin_out`.
- R4: Register 2 reads the pad levels through two flops. A change on `pin_in` that is held stable is not visible after the first rising edge and is visible after the second.
- R5: Only channels 16 to 23 can pulse. Bit k of register 3 (bits 7:0) selects channel 16+k. Channels 0 to 15 never pulse.
- R6: A write to register 5 with bit 0 set, while no pulse is running and the length is nonzero, starts a pulse in the clock edge of the write. The selected channels stay high, and bit 0 of register 5 reads 1, for exactly the number of cycles in register 4 (bits 19:0). Both then return to low and 0.
- R7: All selected channels rise on the same edge and fall on the same edge.
- R8: A start request that arrives while a pulse is running has no effect, even in the pulse's last cycle. The pulse does not get longer.
- R9: Writes to register 3 or register 4 during a pulse do not change the pulse that is running.
- R10: A start with a length of zero produces no pulse, and the busy flag stays 0.
- R11: While a pulse runs, it forces 1 on each selected channel. Unselected channels keep driving register 1. `pin_oe` stays equal to register 0.
- R12: Registers 0, 1, 3 and 4 read back what was written, with bits above their width reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 24 | Pad input levels |
| pin_out | output | 24 | Pad output levels |
| pin_oe | output | 24 | Pad output enables, 1 = drive |

## Verification
Two functions can land in the same cycle: a new start request and the last active cycle of a running pulse. The bench times a start write so that it is taken on the very edge where the counter expires. It then checks that the channels fall and the busy flag clears exactly when the first pulse's length runs out, with no second pulse. A second case puts a length write and a mask write inside a running pulse. The bench judges this by the width of the current pulse and by reading back the new values.

// File: rtl/gpio_pulse_pkg.sv
package gpio_pulse_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_DIR   = 3'd0;
  localparam logic [ADDR_W-1:0] A_OUT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_IN    = 3'd2;
  localparam logic [ADDR_W-1:0] A_PSEL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PLEN  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd5;

  localparam int unsigned CTRL_GO_BIT = 0;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stg1_q, stg2_q;
  logic [W-1:0] stg1_d, stg2_d;

  always_comb begin
    stg1_d = d_async;
    stg2_d = stg1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= stg1_d;
      stg2_q <= stg2_d;
    end
  end

  assign d_sync = stg2_q;

  AST_SYNC_SECOND_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    stg2_q == $past(stg1_q)); // R4
endmodule

// File: rtl/gpio_pulse_timer.sv
module gpio_pulse_timer #(
  parameter int unsigned LEN_W   = 20,
  parameter int unsigned N_PULSE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic [LEN_W-1:0]   len_cfg,
  input  logic [N_PULSE-1:0] sel_cfg,
  output logic               active,
  output logic [N_PULSE-1:0] sel_held
);
  logic               busy_q, busy_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d;
  logic [N_PULSE-1:0] sel_q, sel_d;
  logic               accept;

  assign accept = start_req && !busy_q && (len_cfg != '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = len_cfg;
      sel_d  = sel_cfg;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == LEN_W'(1)) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sel_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
    end
  end

  assign active   = busy_q;
  assign sel_held = sel_q;

  AST_END_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == LEN_W'(1))); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_req && cnt_q != LEN_W'(1)) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1)); // R8
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(sel_q)); // R9
  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start_req && len_cfg == '0) |=> !busy_q); // R10
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pulse_pkg::*;
#(
  parameter int unsigned N_CH    = 24,
  parameter int unsigned N_PULSE = 8,
  parameter int unsigned LEN_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [N_CH-1:0]    in_snap,
  input  logic               busy,
  output logic [N_CH-1:0]    dir,
  output logic [N_CH-1:0]    outval,
  output logic [N_PULSE-1:0] psel,
  output logic [LEN_W-1:0]   plen,
  output logic               start_req,
  output logic [DATA_W-1:0]  rdata
);
  logic [N_CH-1:0]    dir_q, dir_d, out_q, out_d;
  logic [N_PULSE-1:0] psel_q, psel_d;
  logic [LEN_W-1:0]   plen_q, plen_d;
  logic               en_dir, en_out, en_psel, en_plen;

  always_comb begin
    en_dir  = wr_en && (addr == A_DIR);
    en_out  = wr_en && (addr == A_OUT);
    en_psel = wr_en && (addr == A_PSEL);
    en_plen = wr_en && (addr == A_PLEN);
    dir_d   = en_dir  ? wdata[N_CH-1:0]    : dir_q;
    out_d   = en_out  ? wdata[N_CH-1:0]    : out_q;
    psel_d  = en_psel ? wdata[N_PULSE-1:0] : psel_q;
    plen_d  = en_plen ? wdata[LEN_W-1:0]   : plen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      psel_q <= '0;
      plen_q <= '0;
    end else begin
      dir_q  <= dir_d;
      out_q  <= out_d;
      psel_q <= psel_d;
      plen_q <= plen_d;
    end
  end

  assign start_req = wr_en && (addr == A_CTRL) && wdata[CTRL_GO_BIT];

  always_comb begin
    case (addr)
      A_DIR:   rdata = DATA_W'(dir_q);
      A_OUT:   rdata = DATA_W'(out_q);
      A_IN:    rdata = DATA_W'(in_snap);
      A_PSEL:  rdata = DATA_W'(psel_q);
      A_PLEN:  rdata = DATA_W'(plen_q);
      A_CTRL:  rdata = DATA_W'(busy);
      default: rdata = '0;
    endcase
  end

  assign dir    = dir_q;
  assign outval = out_q;
  assign psel   = psel_q;
  assign plen   = plen_q;

  AST_DIR_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> (dir_q == $past(wdata[N_CH-1:0]))); // R2
  AST_LEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_PLEN) |=> $stable(plen_q)); // R12
endmodule

// File: rtl/gpio_pulse_unit.sv
module gpio_pulse_unit
  import gpio_pulse_pkg::*;
#(
  parameter int unsigned N_CH       = 24,
  parameter int unsigned N_PULSE    = 8,
  parameter int unsigned PULSE_BASE = 16,
  parameter int unsigned LEN_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_CH-1:0]   pin_in,
  output logic [N_CH-1:0]   pin_out,
  output logic [N_CH-1:0]   pin_oe
);
  localparam int unsigned PULSE_TOP = PULSE_BASE + N_PULSE - 1;

  logic               rst_meta_q, rst_sync_q;
  logic [N_CH-1:0]    in_snap, dir, outval;
  logic [N_PULSE-1:0] psel, sel_held;
  logic [LEN_W-1:0]   plen;
  logic               start_req, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  gpio_in_sync #(.W(N_CH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .d_async (pin_in),
    .d_sync  (in_snap)
  );

  gpio_regs #(.N_CH(N_CH), .N_PULSE(N_PULSE), .LEN_W(LEN_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .in_snap   (in_snap),
    .busy      (active),
    .dir       (dir),
    .outval    (outval),
    .psel      (psel),
    .plen      (plen),
    .start_req (start_req),
    .rdata     (reg_rdata)
  );

  gpio_pulse_timer #(.LEN_W(LEN_W), .N_PULSE(N_PULSE)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start_req (start_req),
    .len_cfg   (plen),
    .sel_cfg   (psel),
    .active    (active),
    .sel_held  (sel_held)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    if (i >= PULSE_BASE && i <= PULSE_TOP) begin : g_pulse
      assign pin_out[i] = (active && sel_held[i-PULSE_BASE]) ? 1'b1 : outval[i];
    end else begin : g_plain
      assign pin_out[i] = outval[i];
    end
  end

  assign pin_oe = dir;

  AST_GROUP_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    active |-> ((pin_out[PULSE_TOP:PULSE_BASE] & sel_held) == sel_held)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_q |-> (pin_oe == '0 && pin_out == '0)); // R1
endmodule

// File: tb/gpio_pulse_unit_test.sv
`timescale 1ns/1ps
module gpio_pulse_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [23:0] pin_in, pin_out, pin_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } exp_item_t;

  exp_item_t sb_q[$];
  event      smp;

  always #2.5 clk = ~clk;

  gpio_pulse_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // monitor: compares queued expectations against the live outputs
  initial begin
    forever begin
      @(smp);
      while (sb_q.size() > 0) begin
        exp_item_t it;
        logic [31:0] got;
        it = sb_q.pop_front();
        case (it.kind)
          0: got = 32'(pin_out);
          1: got = 32'(pin_oe);
          default: got = reg_rdata;
        endcase
        n_checks++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_val(input int kind, input logic [2:0] a,
                            input logic [31:0] e, input string req);
    exp_item_t it;
    reg_addr = a;
    #0.1;
    it.kind = kind; it.exp = e; it.req = req;
    sb_q.push_back(it);
    -> smp;
    #0.1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0; pin_in = '0;
    repeat (3) tick();
    expect_val(1, 3'd0, 32'h0, "R1 oe in reset");
    expect_val(0, 3'd0, 32'h0, "R1 out in reset");
    rst_n = 1'b1;
    repeat (4) tick();
    expect_val(2, 3'd5, 32'h0, "R1 busy after reset");
    expect_val(2, 3'd0, 32'h0, "R1 dir after reset");
    expect_val(2, 3'd4, 32'h0, "R1 len after reset");

    // R2 / R12 direction
    wr(3'd0, 32'hFFFF_00F0);
    expect_val(1, 3'd0, 32'h00FF_00F0, "R2 oe follows dir");
    expect_val(2, 3'd0, 32'h00FF_00F0, "R12 dir readback");

    // R3 output level
    wr(3'd1, 32'h00A5_5A3C);
    expect_val(0, 3'd1, 32'h00A5_5A3C, "R3 output level");

    // R12 masks
    wr(3'd3, 32'h0000_01FF);
    expect_val(2, 3'd3, 32'h0000_00FF, "R12 mask readback");
    wr(3'd4, 32'hFFFF_FFFF);
    expect_val(2, 3'd4, 32'h000F_FFFF, "R12 length readback");

    // R4 synchroniser latency
    @(negedge clk); pin_in = 24'h123456;
    expect_val(2, 3'd2, 32'h0, "R4 before edges");
    tick();
    expect_val(2, 3'd2, 32'h0, "R4 after one edge");
    tick();
    expect_val(2, 3'd2, 32'h0012_3456, "R4 after two edges");

    // R6 R7 R11 basic pulse, mask channels 16..19, length 3
    wr(3'd3, 32'h0F);
    wr(3'd4, 32'd3);
    wr(3'd5, 32'h1);
    expect_val(0, 3'd5, 32'h00AF_5A3C, "R6 R11 pulse cycle 1");
    expect_val(2, 3'd5, 32'h1, "R6 busy during pulse");
    expect_val(1, 3'd5, 32'h00FF_00F0, "R11 oe unchanged");
    tick();
    expect_val(0, 3'd5, 32'h00AF_5A3C, "R7 pulse cycle 2");
    tick();
    expect_val(0, 3'd5, 32'h00AF_5A3C, "R6 pulse cycle 3");
    tick();
    expect_val(0, 3'd5, 32'h00A5_5A3C, "R6 R7 pulse ended");
    expect_val(2, 3'd5, 32'h0, "R6 busy cleared");

    // R5 full mask, outputs low on pulse channels
    wr(3'd1, 32'h0000_FFFF);
    wr(3'd3, 32'hFF);
    wr(3'd4, 32'd2);
    wr(3'd5, 32'h1);
    expect_val(0, 3'd5, 32'h00FF_FFFF, "R5 all pulse channels high");
    tick(); tick();
    expect_val(0, 3'd5, 32'h0000_FFFF, "R5 only upper channels pulsed");

    // R8 restart mid pulse, length 5
    wr(3'd3, 32'h01);
    wr(3'd4, 32'd5);
    wr(3'd5, 32'h1);            // returns at cycle 1
    wr(3'd5, 32'h1);            // taken in cycle 2, returns at cycle 3
    expect_val(0, 3'd5, 32'h0001_FFFF, "R8 still pulsing cycle 3");
    tick(); tick();
    expect_val(0, 3'd5, 32'h0001_FFFF, "R8 cycle 5 high");
    tick();
    expect_val(0, 3'd5, 32'h0000_FFFF, "R8 not extended");

    // R8 start in the last active cycle, length 3
    wr(3'd4, 32'd3);
    wr(3'd5, 32'h1);            // cycle 1
    tick();                     // cycle 2
    wr(3'd5, 32'h1);            // taken on the expiring edge
    expect_val(0, 3'd5, 32'h0000_FFFF, "R8 last cycle start ignored");
    expect_val(2, 3'd5, 32'h0, "R8 busy clear after last cycle start");
    tick();
    expect_val(0, 3'd5, 32'h0000_FFFF, "R8 no second pulse");

    // R9 length and mask change mid pulse, length 4
    wr(3'd4, 32'd4);
    wr(3'd5, 32'h1);            // cycle 1
    @(negedge clk); reg_addr = 3'd4; reg_wdata = 32'd10; reg_wr = 1'b1;
    @(negedge clk); reg_addr = 3'd3; reg_wdata = 32'h80;
    @(negedge clk); reg_wr = 1'b0; // now cycle 4
    expect_val(0, 3'd5, 32'h0001_FFFF, "R9 mask unchanged mid pulse");
    tick();
    expect_val(0, 3'd5, 32'h0000_FFFF, "R9 length unchanged mid pulse");
    expect_val(2, 3'd4, 32'd10, "R9 new length stored");

    // R10 zero length
    wr(3'd4, 32'd0);
    wr(3'd5, 32'h1);
    expect_val(0, 3'd5, 32'h0000_FFFF, "R10 no pulse");
    expect_val(2, 3'd5, 32'h0, "R10 busy stays clear");
    tick();
    expect_val(0, 3'd5, 32'h0000_FFFF, "R10 still no pulse");

    tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule